// File: doc/BRIEF.md
# Unlock-Cycle Flash Erase and Program Sequencer

This block runs the complete write cycle for one bank of a byte-wide parallel flash that uses the unlock-cycle command protocol. On a start pulse it either erases the selected bank or programs it byte by byte from a source buffer. For each byte it reads the source through a simple index/data pair. After every command it polls the flash by reading the bank base twice and comparing the two values. It then writes a reset command and reads the whole bank back to confirm the result.

Every flash write is followed by a fixed pause of `CYC_PER_US` clock cycles, which stands for the one-microsecond spacing the flash needs between command cycles. Polling is bounded by `POLL_LIMIT` iterations. When polling runs out during a program, no further bytes are written, and the sequencer still resets the flash and verifies the bank. The result is reported with a one-cycle `done` pulse and a held `error` flag.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is active and after it is released with no start, `busy`, `done`, `error`, `flWe` and `flRe` are all 0.
- R2: Every erase and every programmed byte begins with the unlock pair: 0xAA written to base+0x555, then 0x55 written to base+0x2AA.
- R3: An erase issues exactly six command writes. The unlock pair comes first, then 0x80 to base+0x555, 0xAA to base+0x555, 0x55 to base+0x2AA, and finally 0x30 to base.
- R4: A program run handles bytes i = 0 to `BANK_BYTES`-1 in ascending order. For each byte it writes the unlock pair, then 0xA0 to base+0x555, then the source byte for index i to base+i.
- R5: After each flash write, exactly `CYC_PER_US` cycles pass with neither strobe asserted, and the next flash access follows in the very next cycle. `flWe` and `flRe` are never high together.
- R6: After each erase command or programmed byte, the block polls in iterations. Each iteration is two back-to-back reads of base. Read data is taken on `flRdData` one cycle after the `flRe` cycle. An iteration whose two values are equal ends the polling.
- R7: If `POLL_LIMIT` iterations all see two different values, `error` is set and no further bytes are programmed. The block goes straight on to the reset and verify steps.
- R8: After polling ends, the block writes 0xF0 to base and observes the same pause. It then reads base+0 up to base+`BANK_BYTES`-1 in ascending order.
- R9: Verify expects 0xFF in every byte after an erase, and the source byte for that index after a program. The first mismatch sets `error` and ends the verify at that byte.
- R10: `busy` rises in the cycle after an accepted start and stays high until `done`. `done` is a single-cycle pulse. `error` is cleared when a start is accepted and holds its final value after `done`.
- R11: Start pulses that arrive while `busy` is high are ignored. If both starts are high together, the erase is taken.
- R12: `bankSel` is latched when a start is accepted. Every flash address is offset by bank × `BANK_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startErase | input | 1 | Pulse to erase the selected bank |
| startProgram | input | 1 | Pulse to program the selected bank from the source |
| bankSel | input | BANK_W | Bank to operate on, latched at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| error | output | 1 | Timeout or verify mismatch in the last operation |
| flAddr | output | AW | Flash byte address |
| flWrData | output | 8 | Flash write data |
| flWe | output | 1 | Flash write strobe, one cycle per write |
| flRe | output | 1 | Flash read strobe, data expected the next cycle |
| flRdData | input | 8 | Flash read data |
| srcIdx | output | $clog2(BANK_BYTES) | Index of the source byte wanted |
| srcData | input | 8 | Source byte for `srcIdx`, combinational |

## Verification
The assertions take for granted that the flash returns read data exactly one cycle after the read strobe. They also assume that `srcData` follows `srcIdx` within the same cycle and that `CYC_PER_US` is at least 1. The bench flash model answers every read on the next edge. Its source pattern is a pure function of the index and never produces a command byte (0xA0 or 0xF0), so a data write cannot be mistaken for a command. Start pulses are driven for one cycle at the falling edge, so each one is seen at exactly one rising edge.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [1:0] {
    AD_UNLK1,
    AD_UNLK2,
    AD_BASE,
    AD_BYTE
  } addrSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       we;
    logic       re;
    addrSel_e   addrSel;
    logic       useSrc;
    logic [7:0] cmdByte;
    logic       rdCap;
    logic       pollInc;
    logic       idxClr;
    logic       idxInc;
    logic       bankLoad;
    logic       expBlank;
  } strobe_t;

  typedef struct packed {
    addrSel_e   sel;
    logic [7:0] val;
  } step_t;

  localparam logic [11:0] OFF_UNLK1  = 12'h555;
  localparam logic [11:0] OFF_UNLK2  = 12'h2AA;
  localparam logic [7:0]  CMD_KEY1   = 8'hAA;
  localparam logic [7:0]  CMD_KEY2   = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;

  // Command step table: erase has steps 0..5, program has steps 0..3
  function automatic step_t stepInfo(input logic erase, input logic [2:0] step);
    step_t s;
    case (step)
      3'd0:    s = '{sel: AD_UNLK1, val: CMD_KEY1};
      3'd1:    s = '{sel: AD_UNLK2, val: CMD_KEY2};
      3'd2:    s = erase ? '{sel: AD_UNLK1, val: CMD_ERASE}
                         : '{sel: AD_UNLK1, val: CMD_PROG};
      3'd3:    s = erase ? '{sel: AD_UNLK1, val: CMD_KEY1}
                         : '{sel: AD_BYTE, val: 8'h00};
      3'd4:    s = '{sel: AD_UNLK2, val: CMD_KEY2};
      default: s = '{sel: AD_BASE, val: CMD_SECTOR};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flseq_dp.sv
module flseq_dp
  import flseq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int BANK_W     = 1,
  parameter int BANK_BYTES = 8192,
  parameter int CYC_PER_US = 250,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       st,
  input  logic [BANK_W-1:0]             bankSel,
  input  logic [7:0]                    flRdData,
  input  logic [7:0]                    srcData,
  output logic [AW-1:0]                 flAddr,
  output logic [7:0]                    flWrData,
  output logic                          flWe,
  output logic                          flRe,
  output logic [$clog2(BANK_BYTES)-1:0] srcIdx,
  output logic                          dlyDone,
  output logic                          xorZero,
  output logic                          pollLast,
  output logic                          idxLast,
  output logic                          rdMatch
);

  localparam int IDX_W  = $clog2(BANK_BYTES);
  localparam int DLY_W  = $clog2(CYC_PER_US + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic [BANK_W-1:0] bankQ;
  logic [IDX_W-1:0]  idx;
  logic [DLY_W-1:0]  dlyCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [7:0]        firstRd;
  logic [AW-1:0]     baseAddr;
  logic [AW-1:0]     offset;

  assign baseAddr = AW'(bankQ) * AW'(BANK_BYTES);

  always_comb begin
    case (st.addrSel)
      AD_UNLK1: offset = AW'(OFF_UNLK1);
      AD_UNLK2: offset = AW'(OFF_UNLK2);
      AD_BASE:  offset = '0;
      default:  offset = AW'(idx);
    endcase
  end

  assign flAddr   = baseAddr + offset;
  assign flWrData = st.useSrc ? srcData : st.cmdByte;
  assign flWe     = st.we;
  assign flRe     = st.re;
  assign srcIdx   = idx;

  assign dlyDone  = dlyCnt <= DLY_W'(1);
  assign xorZero  = (firstRd ^ flRdData) == 8'h00;
  assign pollLast = pollCnt == POLL_W'(POLL_LIMIT - 1);
  assign idxLast  = idx == IDX_W'(BANK_BYTES - 1);
  assign rdMatch  = flRdData == (st.expBlank ? BLANK_BYTE : srcData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ   <= '0;
      idx     <= '0;
      dlyCnt  <= '0;
      pollCnt <= '0;
      firstRd <= '0;
    end else begin
      if (st.bankLoad) bankQ <= bankSel;
      if (st.idxClr)      idx <= '0;
      else if (st.idxInc) idx <= idx + IDX_W'(1);
      if (st.we)                dlyCnt <= DLY_W'(CYC_PER_US);
      else if (dlyCnt != '0)    dlyCnt <= dlyCnt - DLY_W'(1);
      if (st.we)           pollCnt <= '0;
      else if (st.pollInc) pollCnt <= pollCnt + POLL_W'(1);
      if (st.rdCap) firstRd <= flRdData;
    end
  end

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (st.we || st.re) |-> dlyCnt == '0); // R5

  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT)); // R7

endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startErase,
  input  logic    startProgram,
  input  logic    dlyDone,
  input  logic    xorZero,
  input  logic    pollLast,
  input  logic    idxLast,
  input  logic    rdMatch,
  output strobe_t st,
  output logic    busy,
  output logic    done,
  output logic    error
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_GAP, S_RD1, S_RD2, S_CHK,
    S_RST, S_RGAP, S_VRD, S_VCHK, S_FIN
  } state_e;

  state_e     state, nxt;
  logic       opErase;
  logic [2:0] step;
  logic       errQ;
  logic       lastStep;
  step_t      si;

  assign lastStep = opErase ? (step == 3'd5) : (step == 3'd3);

  always_comb begin
    st          = '0;
    st.expBlank = opErase;
    nxt         = state;
    si          = stepInfo(opErase, step);
    case (state)
      S_IDLE: if (startErase || startProgram) begin
        st.bankLoad = 1'b1;
        st.idxClr   = 1'b1;
        nxt         = S_CMD;
      end
      S_CMD: begin
        st.we      = 1'b1;
        st.addrSel = si.sel;
        st.cmdByte = si.val;
        st.useSrc  = (si.sel == AD_BYTE);
        nxt        = S_GAP;
      end
      S_GAP: if (dlyDone) nxt = lastStep ? S_RD1 : S_CMD;
      S_RD1: begin
        st.re      = 1'b1;
        st.addrSel = AD_BASE;
        nxt        = S_RD2;
      end
      S_RD2: begin
        st.re      = 1'b1;
        st.addrSel = AD_BASE;
        st.rdCap   = 1'b1;
        nxt        = S_CHK;
      end
      S_CHK: begin
        if (xorZero) begin
          if (opErase || idxLast) nxt = S_RST;
          else begin
            st.idxInc = 1'b1;
            nxt       = S_CMD;
          end
        end else if (pollLast) begin
          nxt = S_RST;
        end else begin
          st.pollInc = 1'b1;
          nxt        = S_RD1;
        end
      end
      S_RST: begin
        st.we      = 1'b1;
        st.addrSel = AD_BASE;
        st.cmdByte = CMD_RESET;
        st.idxClr  = 1'b1;
        nxt        = S_RGAP;
      end
      S_RGAP: if (dlyDone) nxt = S_VRD;
      S_VRD: begin
        st.re      = 1'b1;
        st.addrSel = AD_BYTE;
        nxt        = S_VCHK;
      end
      S_VCHK: begin
        if (!rdMatch || idxLast) nxt = S_FIN;
        else begin
          st.idxInc = 1'b1;
          nxt       = S_VRD;
        end
      end
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opErase <= 1'b0;
      step    <= '0;
      errQ    <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && (startErase || startProgram)) begin
        opErase <= startErase;
        step    <= '0;
        errQ    <= 1'b0;
      end
      if (state == S_GAP && dlyDone && !lastStep) step <= step + 3'd1;
      if (state == S_CHK && xorZero && !opErase && !idxLast) step <= '0;
      if (state == S_CHK && !xorZero && pollLast) errQ <= 1'b1;
      if (state == S_VCHK && !rdMatch) errQ <= 1'b1;
    end
  end

  assign busy  = state != S_IDLE;
  assign done  = state == S_FIN;
  assign error = errQ;

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(st.we && st.re)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (startErase || startProgram)) |=> busy); // R10

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flseq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int BANK_W     = 1,
  parameter int BANK_BYTES = 8192,
  parameter int CYC_PER_US = 250,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startErase,
  input  logic                          startProgram,
  input  logic [BANK_W-1:0]             bankSel,
  output logic                          busy,
  output logic                          done,
  output logic                          error,
  output logic [AW-1:0]                 flAddr,
  output logic [7:0]                    flWrData,
  output logic                          flWe,
  output logic                          flRe,
  input  logic [7:0]                    flRdData,
  output logic [$clog2(BANK_BYTES)-1:0] srcIdx,
  input  logic [7:0]                    srcData
);

  strobe_t st;
  logic    dlyDone, xorZero, pollLast, idxLast, rdMatch;

  flseq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startErase  (startErase),
    .startProgram(startProgram),
    .dlyDone     (dlyDone),
    .xorZero     (xorZero),
    .pollLast    (pollLast),
    .idxLast     (idxLast),
    .rdMatch     (rdMatch),
    .st          (st),
    .busy        (busy),
    .done        (done),
    .error       (error)
  );

  flseq_dp #(
    .AW        (AW),
    .BANK_W    (BANK_W),
    .BANK_BYTES(BANK_BYTES),
    .CYC_PER_US(CYC_PER_US),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .bankSel (bankSel),
    .flRdData(flRdData),
    .srcData (srcData),
    .flAddr  (flAddr),
    .flWrData(flWrData),
    .flWe    (flWe),
    .flRe    (flRe),
    .srcIdx  (srcIdx),
    .dlyDone (dlyDone),
    .xorZero (xorZero),
    .pollLast(pollLast),
    .idxLast (idxLast),
    .rdMatch (rdMatch)
  );

endmodule

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;

  localparam int BB  = 64;
  localparam int CYC = 3;
  localparam int PL  = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startErase = 1'b0, startProgram = 1'b0;
  logic [0:0] bankSel = 1'b0;
  logic       busy, done, error, flWe, flRe;
  logic [15:0] flAddr;
  logic [7:0]  flWrData, srcData;
  logic [7:0]  flRdData = 8'h00;
  logic [5:0]  srcIdx;

  always #2 clk = ~clk;

  function automatic logic [7:0] srcPat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  assign srcData = srcPat(int'(srcIdx));

  flash_prog_seq #(.AW(16), .BANK_W(1), .BANK_BYTES(BB), .CYC_PER_US(CYC), .POLL_LIMIT(PL))
  u_flash_prog_seq (
    .clk(clk), .rstN(rstN), .startErase(startErase), .startProgram(startProgram),
    .bankSel(bankSel), .busy(busy), .done(done), .error(error), .flAddr(flAddr),
    .flWrData(flWrData), .flWe(flWe), .flRe(flRe), .flRdData(flRdData),
    .srcIdx(srcIdx), .srcData(srcData)
  );

  // Flash model
  logic [7:0] mem [0:2*BB-1];
  logic [7:0] lastCmd = 8'h00;
  int  busyReads = 0;
  bit  tog = 1'b0;
  bit  stuck = 1'b0, corruptEn = 1'b0, fillReq = 1'b0;
  int  corruptAt = 0;
  logic [7:0] fillVal = 8'hFF;

  always @(posedge clk) begin
    if (fillReq) for (int j = 0; j < 2*BB; j++) mem[j] <= fillVal;
    if (flWe) begin
      lastCmd <= flWrData;
      if (lastCmd == 8'hA0) begin
        mem[flAddr[6:0]] <= (corruptEn && int'(flAddr[6:0]) == corruptAt) ? (flWrData ^ 8'h01) : flWrData;
        busyReads <= 4;
      end else if (flWrData == 8'h30) begin
        for (int j = 0; j < BB; j++)
          mem[{flAddr[6], 6'(j)}] <= (corruptEn && int'({flAddr[6], 6'(j)}) == corruptAt) ? 8'h00 : 8'hFF;
        busyReads <= 4;
      end
    end
    if (flRe) begin
      if (stuck || busyReads > 0) begin
        tog <= !tog;
        flRdData <= tog ? 8'h44 : 8'h04;
        if (busyReads > 0) busyReads <= busyReads - 1;
      end else begin
        flRdData <= mem[flAddr[6:0]];
      end
    end
  end

  // Activity monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int nW, nR, spacingBad, doneCnt, rstRd, lastAct;
  bit lastWr, clrReq = 1'b0;
  logic [15:0] wrA [0:511];
  logic [7:0]  wrD [0:511];
  logic [15:0] rdA [0:1023];

  always @(negedge clk) begin
    if (clrReq) begin
      nW = 0; nR = 0; spacingBad = 0; doneCnt = 0; rstRd = -1; lastWr = 1'b0; lastAct = 0;
    end else begin
      if (flWe || flRe) begin
        if (lastWr && (cyc - lastAct) != CYC + 1) spacingBad++;
        if (flWe && flRe) spacingBad++;
        lastAct = cyc;
        lastWr = flWe;
      end
      if (flWe) begin
        if (nW < 512) begin wrA[nW] = flAddr; wrD[nW] = flWrData; end
        nW++;
        if (flWrData == 8'hF0 && rstRd < 0) rstRd = nR;
      end
      if (flRe) begin
        if (nR < 1024) rdA[nR] = flAddr;
        nR++;
      end
      if (done) doneCnt++;
    end
  end

  int nChk = 0, nFail = 0;
  bit errAtDone;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input logic [7:0] v);
    fillVal = v;
    @(negedge clk); fillReq = 1'b1; clrReq = 1'b1;
    @(negedge clk); #1 fillReq = 1'b0; clrReq = 1'b0;
  endtask

  task automatic runOp(input bit er, input bit pr, input logic bnk);
    int n;
    @(negedge clk);
    bankSel = bnk; startErase = er; startProgram = pr;
    @(negedge clk);
    startErase = 1'b0; startProgram = 1'b0;
    chk(busy === 1'b1 && error === 1'b0, "R10", "busy/error after start", int'(busy) * 2 + int'(error), 2);
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R10", "done seen", n, 0);
    errAtDone = error;
    repeat (3) @(negedge clk);
    chk(error === errAtDone && busy === 1'b0, "R10", "error held after done", int'(error), int'(errAtDone));
    chk(doneCnt == 1, "R10", "done pulse count", doneCnt, 1);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && error === 0 && flWe === 0 && flRe === 0, "R1", "outputs in reset",
        int'({busy, done, error, flWe, flRe}), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && error === 0 && flWe === 0 && flRe === 0, "R1", "outputs idle after reset",
        int'({busy, done, error, flWe, flRe}), 0);
  endtask

  task automatic t_erase;
    int bad2 = 0, bad3 = 0, badV = 0, badP = 0, badM = 0;
    logic [15:0] ea [0:5];
    logic [7:0]  ed [0:5];
    ea = '{16'h0595, 16'h02EA, 16'h0595, 16'h0595, 16'h02EA, 16'h0040};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    prep(8'h5A);
    runOp(1'b1, 1'b0, 1'b1);
    chk(nW == 7, "R3", "erase write count", nW, 7);
    for (int k = 0; k < 2; k++) if (wrA[k] != ea[k] || wrD[k] != ed[k]) bad2++;
    for (int k = 2; k < 6; k++) if (wrA[k] != ea[k] || wrD[k] != ed[k]) bad3++;
    chk(bad2 == 0, "R2", "erase unlock pair", bad2, 0);
    chk(bad3 == 0, "R3", "erase command tail (R12 bank 1 base 0x40)", bad3, 0);
    chk(wrA[6] == 16'h0040 && wrD[6] == 8'hF0, "R8", "reset write", int'(wrD[6]), 8'hF0);
    chk(rstRd == 6, "R6", "erase poll read count", rstRd, 6);
    for (int k = 0; k < rstRd && k < 1024; k++) if (rdA[k] != 16'h0040) badP++;
    chk(badP == 0, "R6", "poll reads at base", badP, 0);
    chk(nR - rstRd == BB, "R8", "verify read count", nR - rstRd, BB);
    for (int k = 0; k < BB; k++) if (rdA[rstRd + k] != 16'(64 + k)) badV++;
    chk(badV == 0, "R8", "verify addresses ascending", badV, 0);
    for (int k = 0; k < BB; k++) if (mem[64 + k] != 8'hFF || mem[k] != 8'h5A) badM++;
    chk(badM == 0, "R12", "only bank 1 erased", badM, 0);
    chk(errAtDone == 1'b0, "R9", "clean erase error", int'(errAtDone), 0);
    chk(spacingBad == 0, "R5", "write spacing in erase", spacingBad, 0);
  endtask

  task automatic t_program;
    int bad2 = 0, bad4 = 0, badM = 0;
    prep(8'hFF);
    runOp(1'b0, 1'b1, 1'b0);
    chk(nW == 4 * BB + 1, "R4", "program write count", nW, 4 * BB + 1);
    for (int i = 0; i < BB; i++) begin
      if (wrA[4*i] != 16'h0555 || wrD[4*i] != 8'hAA || wrA[4*i+1] != 16'h02AA || wrD[4*i+1] != 8'h55) bad2++;
      if (wrA[4*i+2] != 16'h0555 || wrD[4*i+2] != 8'hA0 || wrA[4*i+3] != 16'(i) || wrD[4*i+3] != srcPat(i)) bad4++;
    end
    chk(bad2 == 0, "R2", "program unlock pairs", bad2, 0);
    chk(bad4 == 0, "R4", "program command and data writes", bad4, 0);
    for (int i = 0; i < BB; i++) if (mem[i] != srcPat(i)) badM++;
    chk(badM == 0, "R4", "flash contents after program", badM, 0);
    chk(rstRd == 6 * BB, "R6", "program poll reads", rstRd, 6 * BB);
    chk(nR - rstRd == BB, "R8", "program verify reads", nR - rstRd, BB);
    chk(errAtDone == 1'b0, "R9", "clean program error", int'(errAtDone), 0);
    chk(spacingBad == 0, "R5", "write spacing in program", spacingBad, 0);
  endtask

  task automatic t_busy_ignore;
    int n, badM = 0;
    prep(8'hFF);
    @(negedge clk); bankSel = 1'b0; startErase = 1'b1;
    @(negedge clk); startErase = 1'b0;
    repeat (5) @(negedge clk);
    bankSel = 1'b1; startProgram = 1'b1;
    @(negedge clk); startProgram = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    chk(nW == 7 && wrA[5] == 16'h0000, "R11", "start while busy ignored", nW, 7);
    for (int k = 0; k < BB; k++) if (mem[64 + k] != 8'hFF) badM++;
    chk(badM == 0 && busy === 1'b0, "R11", "bank 1 untouched", badM, 0);
  endtask

  task automatic t_both;
    prep(8'h5A);
    runOp(1'b1, 1'b1, 1'b1);
    chk(nW == 7 && wrD[2] == 8'h80, "R11", "erase wins over program", int'(wrD[2]), 8'h80);
  endtask

  task automatic t_timeout;
    stuck = 1'b1;
    prep(8'hFF);
    runOp(1'b0, 1'b1, 1'b0);
    stuck = 1'b0;
    chk(errAtDone == 1'b1, "R7", "timeout error", int'(errAtDone), 1);
    chk(nW == 5 && wrD[4] == 8'hF0, "R7", "no bytes after timeout", nW, 5);
    chk(rstRd == 2 * PL, "R7", "poll reads before giving up", rstRd, 2 * PL);
  endtask

  task automatic t_mismatch;
    corruptEn = 1'b1; corruptAt = 64 + 10;
    prep(8'h5A);
    runOp(1'b1, 1'b0, 1'b1);
    chk(errAtDone == 1'b1, "R9", "erase verify mismatch", int'(errAtDone), 1);
    chk(nR - rstRd == 11, "R9", "erase verify stops at mismatch", nR - rstRd, 11);
    corruptAt = 20;
    prep(8'hFF);
    runOp(1'b0, 1'b1, 1'b0);
    corruptEn = 1'b0;
    chk(errAtDone == 1'b1, "R9", "program verify mismatch", int'(errAtDone), 1);
    chk(nR - rstRd == 21 && nW == 4 * BB + 1, "R9", "program verify stops at mismatch", nR - rstRd, 21);
    prep(8'h5A);
    runOp(1'b1, 1'b0, 1'b0);
    chk(errAtDone == 1'b0, "R10", "error cleared by next clean run", int'(errAtDone), 0);
  endtask

  initial begin
    bit wdHit = 1'b0;
    @(negedge clk); clrReq = 1'b1;
    @(negedge clk); #1 clrReq = 1'b0;
    fork
      begin
        t_reset();
        t_erase();
        t_program();
        t_busy_ignore();
        t_both();
        t_timeout();
        t_mismatch();
      end
      begin
        repeat (200000) @(posedge clk);
        wdHit = 1'b1;
      end
    join_any
    disable fork;
    if (wdHit) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule